// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block generates a periodic timeout from a free-running binary divider clocked by the reference clock. A 3-bit rate code selects one tap of the divider, so the period is a power of two of reference clocks. Each time the selected tap rises, a sticky timeout flag is set. An interrupt request is raised while the flag and the enable bit are both set. Software clears the flag by writing a one to it.

Two 8-bit registers share a small write/read bus: a control register and a flag register. The control register holds the enable, two halt controls, a test bypass and the rate code. One halt control freezes the divider while the system is in wait. The other freezes it while the system is halted for debug. The bypass bit replaces the first 2^13 stage of the chain with a divide-by-4 stage, so tests can reach every rate quickly. Some bits have write rules that depend on a special-mode input.

Top module: `rti_timer`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_o` is low.
- R2: With bypass clear, rate code k (1..7) sets the flag once every 2^(12+k) reference clocks, from 2^13 for code 1 up to 2^19 for code 7.
- R3: With bypass set, rate code k sets the flag once every 2^(k+1) clocks. The first divider stage becomes divide-by-4 instead of divide-by-2^13.
- R4: Rate code 0 disables the timeout, and the flag is never set.
- R5: The bypass bit (control bit 3) takes a written value only while `special_mode_i` is high. In normal mode, writes leave it unchanged.
- R6: The two halt bits (control bit 6 for wait, bit 5 for debug) are write-once in normal mode. The first control write in normal mode after reset locks them, whatever value it writes. Only reset clears the lock. In special mode they can be written at any time.
- R7: While the wait-halt bit is set and `wait_i` is high, the divider holds its value, so the next flag is delayed by exactly the number of halted cycles. With the bit clear, `wait_i` has no effect.
- R8: While the debug-halt bit is set and `dbg_i` is high, the divider holds its value in the same way. With the bit clear, `dbg_i` has no effect.
- R9: The flag stays set until a write to the flag register (address 1) with bit 7 set. A write to that register with bit 7 clear leaves the flag unchanged.
- R10: If a flag-clear write and a new timeout fall in the same cycle, the flag ends up set.
- R11: `irq_o` is high exactly when the enable bit (control bit 7) and the flag are both set.
- R12: Control register layout: bit 7 enable, bit 6 wait-halt, bit 5 debug-halt, bit 4 reserved and reads 0, bit 3 bypass, bits 2:0 rate. The flag register returns the flag in bit 7 and 0 in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that drives the divider |
| rst_ni | input | 1 | Asynchronous reset, active low |
| special_mode_i | input | 1 | High in special (test) mode, which relaxes the write rules |
| wait_i | input | 1 | System is in wait |
| dbg_i | input | 1 | System is halted for debug |
| wr_en_i | input | 1 | Write strobe for the register bus |
| addr_i | input | 1 | Register select: 0 control, 1 flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the register selected by `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the interval between successive flag rises for several rate codes, in both the bypassed and the full chain. A wrong tap index or a wrong bypass width shows up as an interval off by a power of two. It holds `wait_i` and `dbg_i` for a known number of cycles inside a period, both with the matching halt bit set and with it clear. A design that halts on the wrong condition, or that keeps counting while halted, produces an interval that is not exactly stretched. It lines a flag-clear write up with the edge on which a new timeout arrives. A clear-priority design then reads back 0. It also checks that the first normal-mode write locks the halt bits even when it writes zeros, and that a normal-mode write to the bypass bit is dropped, so a design that locks only on a written one, or that ignores the mode, reads back the wrong control value.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int REG_W   = 8;
  localparam int RATE_W  = 3;
  localparam int NCODE   = (1 << RATE_W) - 1;
  localparam int EN_BIT  = 7;
  localparam int SW_BIT  = 6;
  localparam int SD_BIT  = 5;
  localparam int RSV_BIT = 4;
  localparam int BYP_BIT = 3;
  localparam int FLG_BIT = 7;

  typedef struct packed {
    logic              en;
    logic              stop_wait;
    logic              stop_dbg;
    logic              bypass;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  typedef enum logic {
    REG_CTL = 1'b0,
    REG_FLG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rti_prescaler.sv
module rti_prescaler #(
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R7/R8: a halted chain keeps its value
  a_r7_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == $past(cnt_q));
  a_r2_run_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rti_tap_sel.sv
module rti_tap_sel
  import rti_pkg::*;
#(
  parameter int CNT_W    = 19,
  parameter int PRE_BITS = 13,
  parameter int BYP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              bypass_i,
  output logic              tick_o
);
  // hit[c]: selected tap goes 0->1 on this increment
  logic [NCODE:0] nrm_hit, byp_hit;
  assign nrm_hit[0] = 1'b0;
  assign byp_hit[0] = 1'b0;

  for (genvar c = 1; c <= NCODE; c++) begin : g_code
    localparam int NN = PRE_BITS + c - 2;
    localparam int BN = BYP_BITS + c - 2;
    assign nrm_hit[c] = ~cnt_i[NN] & (&cnt_i[NN-1:0]);
    assign byp_hit[c] = ~cnt_i[BN] & (&cnt_i[BN-1:0]);
  end

  assign tick_o = run_i & (bypass_i ? byp_hit[rate_i] : nrm_hit[rate_i]);

  a_r4_off_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_i == '0 |-> !tick_o);
  a_r3_tick_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             special_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic [REG_W-1:0] rdata_o,
  output ctl_t             ctl_o,
  output logic             flag_o
);
  ctl_t ctl_q;
  logic lock_q, flag_q;
  logic ctl_wr, flag_clr;
  logic unused_rsv;

  assign ctl_wr     = wr_en_i & (reg_sel_e'(addr_i) == REG_CTL);
  assign flag_clr   = wr_en_i & (reg_sel_e'(addr_i) == REG_FLG) & wdata_i[FLG_BIT];
  assign unused_rsv = wdata_i[RSV_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      lock_q <= 1'b0;
    end else if (ctl_wr) begin
      ctl_q.en   <= wdata_i[EN_BIT];
      ctl_q.rate <= wdata_i[RATE_W-1:0];
      if (special_i || !lock_q) begin
        ctl_q.stop_wait <= wdata_i[SW_BIT];
        ctl_q.stop_dbg  <= wdata_i[SD_BIT];
      end
      if (special_i) ctl_q.bypass <= wdata_i[BYP_BIT];
      else           lock_q       <= 1'b1;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (tick_i)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(addr_i) == REG_CTL) begin
      rdata_o[EN_BIT]       = ctl_q.en;
      rdata_o[SW_BIT]       = ctl_q.stop_wait;
      rdata_o[SD_BIT]       = ctl_q.stop_dbg;
      rdata_o[BYP_BIT]      = ctl_q.bypass;
      rdata_o[RATE_W-1:0]   = ctl_q.rate;
    end else begin
      rdata_o[FLG_BIT] = flag_q;
    end
  end

  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr && !tick_i |=> !flag_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr |=> flag_q);
  a_r5_bypass_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !special_i |=> $stable(ctl_q.bypass));
  a_r6_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !special_i |=> $stable(ctl_q.stop_wait) && $stable(ctl_q.stop_dbg));
  a_r12_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[RSV_BIT] == 1'b0);
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int PRE_BITS = 13,
  parameter int BYP_BITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             special_mode_i,
  input  logic             wait_i,
  input  logic             dbg_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int CNT_W = PRE_BITS + NCODE - 1;

  ctl_t             ctl;
  logic             flag, tick, run;
  logic [CNT_W-1:0] cnt;

  assign run = ~(ctl.stop_wait & wait_i) & ~(ctl.stop_dbg & dbg_i);

  rti_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .cnt_o (cnt)
  );

  rti_tap_sel #(.CNT_W(CNT_W), .PRE_BITS(PRE_BITS), .BYP_BITS(BYP_BITS)) u_tap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt),
    .run_i   (run),
    .rate_i  (ctl.rate),
    .bypass_i(ctl.bypass),
    .tick_o  (tick)
  );

  rti_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .special_i(special_mode_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick),
    .rdata_o  (rdata_o),
    .ctl_o    (ctl),
    .flag_o   (flag)
  );

  assign irq_o = ctl.en & flag;

  a_r7_wait_blocks_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.stop_wait && wait_i |-> !tick);
  a_r8_dbg_blocks_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.stop_dbg && dbg_i |-> !tick);
  a_r11_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);
endmodule

// File: tb/rti_timer_tb.sv
`timescale 1ns/1ps
module rti_timer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       special_mode_i = 1'b1;
  logic       wait_i = 1'b0;
  logic       dbg_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rti_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .special_mode_i(special_mode_i),
    .wait_i(wait_i), .dbg_i(dbg_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: time each flag rise, pop the expected interval
  bit     irq_prev = 1'b0, have_last = 1'b0;
  longint last_set = 0;
  always @(negedge clk) begin
    if (irq_o && !irq_prev) begin
      if (have_last && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk((cyc - last_set) == e, "R2/R3/R7/R8 period", cyc - last_set, e);
      end
      last_set  = cyc;
      have_last = 1'b1;
    end
    irq_prev = irq_o;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a; wr_en_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!irq_o);
  endtask

  // hold_sel: 0 none, 1 wait_i, 2 dbg_i
  task automatic measure(input int per, input int n, input int hold_sel, input int hold);
    wr(1'b1, 8'h80);
    wait_rise(); wr(1'b1, 8'h80);
    wait_rise(); wr(1'b1, 8'h80);
    for (int i = 0; i < n; i++) exp_q.push_back(per);
    for (int i = 0; i < n; i++) begin
      if (hold_sel == 1) wait_i = 1'b1;
      if (hold_sel == 2) dbg_i = 1'b1;
      if (hold_sel != 0) repeat (hold) @(negedge clk);
      wait_i = 1'b0; dbg_i = 1'b0;
      wait_rise(); wr(1'b1, 8'h80);
    end
    chk(exp_q.size() == 0, "R2/R3 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 190000);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk(d == 8'h00, "R1 ctl reset", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R1 flag reset", d, 0);
    chk(irq_o == 1'b0, "R1 irq reset", irq_o, 0);

    // R12 layout, R5 bypass writable in special
    wr(1'b0, 8'h99);
    rd(1'b0, d); chk(d == 8'h89, "R12 reserved reads 0, R5 special bypass", d, 8'h89);

    // R3 bypass periods
    wr(1'b0, 8'h89); measure(4, 2, 0, 0);
    wr(1'b0, 8'h8A); measure(8, 2, 0, 0);
    wr(1'b0, 8'h8B); measure(16, 2, 0, 0);
    wr(1'b0, 8'h8F); measure(256, 2, 0, 0);

    // R7 / R8 halting, and no effect when the halt bit is clear
    wr(1'b0, 8'hCB); measure(21, 2, 1, 5);
    wr(1'b0, 8'hCB); measure(16, 1, 2, 5);
    wr(1'b0, 8'hAB); measure(21, 2, 2, 5);
    wr(1'b0, 8'hAB); measure(16, 1, 1, 5);
    wr(1'b0, 8'h8B); measure(16, 1, 1, 7);

    // R9 write of 0 to the flag bit ignored, then one clears
    wr(1'b0, 8'h8B);
    wr(1'b1, 8'h80); wait_rise();
    wr(1'b1, 8'h7F);
    rd(1'b1, d); chk(d == 8'h80, "R9 zero write keeps flag", d, 8'h80);
    wr(1'b1, 8'h80);
    rd(1'b1, d); chk(d == 8'h00, "R9 one write clears, R12 bits 6:0 zero", d, 0);

    // R10 clear lands on a new timeout (period 4)
    wr(1'b0, 8'h89);
    wr(1'b1, 8'h80); wait_rise();
    repeat (2) @(negedge clk);
    wr(1'b1, 8'h80);
    rd(1'b1, d); chk(d == 8'h80, "R10 set wins", d, 8'h80);

    // R11 irq gated by enable
    wr(1'b0, 8'h09);
    repeat (10) @(negedge clk);
    rd(1'b1, d); chk(d == 8'h80, "R11 flag set while disabled", d, 8'h80);
    chk(irq_o == 1'b0, "R11 irq low when disabled", irq_o, 0);
    wr(1'b0, 8'h89);
    chk(irq_o == 1'b1, "R11 irq high when enabled", irq_o, 1);

    // R4 rate 0 off
    wr(1'b0, 8'h88); wr(1'b1, 8'h80);
    repeat (600) @(negedge clk);
    rd(1'b1, d); chk(d == 8'h00, "R4 code 0 never sets", d, 0);
    chk(irq_o == 1'b0, "R4 irq stays low", irq_o, 0);

    // normal mode: leave bypass clear before switching
    wr(1'b0, 8'h00);
    special_mode_i = 1'b0;
    wr(1'b0, 8'h81);
    rd(1'b0, d); chk(d == 8'h81, "R6 first normal write", d, 8'h81);
    wr(1'b0, 8'hF9);
    rd(1'b0, d); chk(d == 8'h81, "R5 R6 R12 locked and bypass ignored", d, 8'h81);

    // R2 full chain
    measure(8192, 1, 0, 0);
    wr(1'b0, 8'h82); measure(16384, 1, 0, 0);

    // R6 special mode writes after lock
    special_mode_i = 1'b1;
    wr(1'b0, 8'hC1);
    rd(1'b0, d); chk(d == 8'hC1, "R6 special overrides lock", d, 8'hC1);

    summary();
    $finish;
  end
endmodule